// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of why the chip was most recently reset. Each reset source has its own input: external hard reset, power-up, software watchdog, double bus fault, loss of clock, software reset and software reset of the peripherals. The block gathers these sources while a reset is in progress. It folds them into an 8-bit status register only when the reset controller pulses the reset-complete strobe.

A power-up completion loads the register with exactly the power-up and external bits and discards everything held before. Every other reset adds its bits on top of those already held, so software should clear the register after each boot to see the newest cause. A supervisor-mode write clears each bit written as one. Reads and writes made outside supervisor mode see zero and change nothing.

Top module: `rst_cause_reg`

## Requirements
- R1: Asserting `rst_n` low clears the register to 0x00 at once, with no clock edge needed.
- R2: The bit layout is: bit 7 external, bit 6 power-up, bit 5 watchdog, bit 4 double bus fault, bit 2 loss of clock, bit 1 software reset, bit 0 software reset of peripherals. On a non-power-up completion, each source seen high in any cycle since the previous completion (including the completion cycle) is ORed into its bit. A source seen only before the previous completion adds nothing.
- R3: A completion whose gathered sources include power-up leaves the register at exactly 0xC0, whatever it held and whatever other sources were seen.
- R4: Without a completion strobe or a supervisor clearing write, the register holds its value, even while sources toggle.
- R5: A supervisor write clears every bit whose write-data bit is one and leaves the bits written as zero unchanged. Several bits may clear in one write.
- R6: Bit 3 is reserved. It always reads 0 and no source or write sets it.
- R7: `rdata_o` equals the register when `rd_en_i` and `sup_i` are both high, and is 0x00 otherwise. A write made with `sup_i` low changes nothing.
- R8: When a clearing write and a completion fall in the same cycle, the bits the completion sets end up set. The other bits written as one end up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the register logic |
| rst_done_i | input | 1 | One-cycle strobe: a reset sequence has finished |
| src_ext_i | input | 1 | External hard reset source active |
| src_pwr_i | input | 1 | Power-up reset source active |
| src_wdog_i | input | 1 | Software watchdog reset source active |
| src_dbf_i | input | 1 | Double bus fault reset source active |
| src_loc_i | input | 1 | Loss-of-clock reset source active |
| src_swr_i | input | 1 | Software reset request active |
| src_swrp_i | input | 1 | Software peripheral reset request active |
| sup_i | input | 1 | Access is made in supervisor mode |
| rd_en_i | input | 1 | Read access this cycle |
| wr_en_i | input | 1 | Write access this cycle |
| wdata_i | input | 8 | Write data; ones select bits to clear |
| rdata_o | output | 8 | Read data, zero unless a supervisor read |

## Verification
The assertions assume that `rst_done_i` is a single-cycle pulse. They also assume that the read path is combinational, so a check at the ports holds in the same cycle as the access. The properties that follow a completion compare the register with the gathered cause from the previous cycle, so they do not depend on how source pulses line up with the strobe. The stimulus drives sources in cycles of their own, in the completion cycle, and between two completions. It also mixes clearing writes into completion cycles, and it never holds the strobe high for more than one cycle.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int DATA_W  = 8;
  localparam int B_EXT   = 7;
  localparam int B_PWR   = 6;
  localparam int B_WDOG  = 5;
  localparam int B_DBF   = 4;
  localparam int B_RSV   = 3;
  localparam int B_LOC   = 2;
  localparam int B_SWR   = 1;
  localparam int B_SWRP  = 0;

  localparam logic [DATA_W-1:0] RSV_MASK   = DATA_W'(1) << B_RSV;
  localparam logic [DATA_W-1:0] LIVE_MASK  = ~RSV_MASK;
  localparam logic [DATA_W-1:0] PWRUP_LOAD = (DATA_W'(1) << B_EXT) | (DATA_W'(1) << B_PWR);

  typedef logic [DATA_W-1:0] cause_t;
endpackage

// File: rtl/rstc_collect.sv
module rstc_collect
  import rstc_pkg::*;
#(
  parameter bit GATHER = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   done_i,
  input  cause_t src_i,
  output cause_t cause_o
);
  generate
    if (GATHER) begin : g_gather
      cause_t pend_q;
      cause_t pend_n;
      logic   pend_en;

      always_comb begin
        pend_en = done_i | (|src_i);
        if (done_i) pend_n = '0;
        else        pend_n = pend_q | src_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q <= '0;
        else if (pend_en) pend_q <= pend_n;
      end

      assign cause_o = (pend_q | src_i) & LIVE_MASK;
    end else begin : g_direct
      assign cause_o = src_i & LIVE_MASK;
    end
  endgenerate
endmodule

// File: rtl/rstc_status.sv
module rstc_status
  import rstc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   done_i,
  input  cause_t cause_i,
  input  cause_t clr_i,
  output cause_t stat_o
);
  cause_t stat_q;
  cause_t stat_n;
  logic   stat_en;
  logic   pwr_evt;

  always_comb begin
    pwr_evt = done_i & cause_i[B_PWR];
    stat_en = done_i | (|clr_i);
    if (pwr_evt)     stat_n = PWRUP_LOAD;
    else if (done_i) stat_n = ((stat_q & ~clr_i) | cause_i) & LIVE_MASK;
    else             stat_n = (stat_q & ~clr_i) & LIVE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_n;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/rstc_port.sv
module rstc_port
  import rstc_pkg::*;
(
  input  logic   sup_i,
  input  logic   rd_en_i,
  input  logic   wr_en_i,
  input  cause_t wdata_i,
  input  cause_t stat_i,
  output cause_t clr_o,
  output cause_t rdata_o
);
  always_comb begin
    clr_o   = (wr_en_i && sup_i) ? (wdata_i & LIVE_MASK) : '0;
    rdata_o = (rd_en_i && sup_i) ? stat_i : '0;
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rstc_pkg::*;
#(
  parameter bit GATHER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_done_i,
  input  logic              src_ext_i,
  input  logic              src_pwr_i,
  input  logic              src_wdog_i,
  input  logic              src_dbf_i,
  input  logic              src_loc_i,
  input  logic              src_swr_i,
  input  logic              src_swrp_i,
  input  logic              sup_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  cause_t src_vec;
  cause_t cause_w;
  cause_t clr_w;
  cause_t stat_q;

  always_comb begin
    src_vec         = '0;
    src_vec[B_EXT]  = src_ext_i;
    src_vec[B_PWR]  = src_pwr_i;
    src_vec[B_WDOG] = src_wdog_i;
    src_vec[B_DBF]  = src_dbf_i;
    src_vec[B_LOC]  = src_loc_i;
    src_vec[B_SWR]  = src_swr_i;
    src_vec[B_SWRP] = src_swrp_i;
  end

  rstc_collect #(.GATHER(GATHER)) u_collect (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (rst_done_i),
    .src_i   (src_vec),
    .cause_o (cause_w)
  );

  rstc_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (rst_done_i),
    .cause_i (cause_w),
    .clr_i   (clr_w),
    .stat_o  (stat_q)
  );

  rstc_port u_port (
    .sup_i   (sup_i),
    .rd_en_i (rd_en_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .stat_i  (stat_q),
    .clr_o   (clr_w),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk
  import rstc_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   done,
  input cause_t cause,
  input cause_t stat,
  input logic   wr_en,
  input logic   sup,
  input logic   rd_en,
  input cause_t rdata
);
  p_pwr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cause[B_PWR]) |=> (stat == PWRUP_LOAD));

  // R2 and R8: completion bits end up set even under a same-cycle clear
  p_or_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cause[B_PWR]) |=> ((stat & $past(cause)) == $past(cause)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !(wr_en && sup)) |=> $stable(stat));

  p_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ((stat & ~$past(stat)) == '0));

  p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat[B_RSV] == 1'b0);

  p_user_blind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && sup) |-> (rdata == '0));

  p_sup_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sup) |-> (rdata == stat));
endmodule

bind rst_cause_reg rst_cause_reg_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .done  (rst_done_i),
  .cause (cause_w),
  .stat  (stat_q),
  .wr_en (wr_en_i),
  .sup   (sup_i),
  .rd_en (rd_en_i),
  .rdata (rdata_o)
);

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // each vector: {sources, clear mask, expected register}
  localparam logic [23:0] VECS [NVEC] = '{
    {8'h40, 8'h00, 8'hC0},
    {8'h20, 8'h00, 8'hE0},
    {8'h00, 8'hC0, 8'h20},
    {8'h14, 8'h00, 8'h34},
    {8'h03, 8'h20, 8'h17},
    {8'h00, 8'hFF, 8'h00},
    {8'h48, 8'h00, 8'hC0},
    {8'h80, 8'h40, 8'h80},
    {8'h08, 8'h00, 8'h80}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       done;
  logic [7:0] src;
  logic       sup, rd_en, wr_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg uut (
    .clk(clk), .rst_n(rst_n), .rst_done_i(done),
    .src_ext_i(src[7]), .src_pwr_i(src[6]), .src_wdog_i(src[5]),
    .src_dbf_i(src[4]), .src_loc_i(src[2]), .src_swr_i(src[1]),
    .src_swrp_i(src[0]), .sup_i(sup), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata=%02h expected=%02h", req, rdata, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] exp);
    @(negedge clk);
    sup = 1'b1; rd_en = 1'b1; src = '0; done = 1'b0; wr_en = 1'b0;
    #1 check(req, exp);
    rd_en = 1'b0;
  endtask

  task automatic cyc(input logic [7:0] s, input logic d, input logic w, input logic [7:0] wd);
    @(negedge clk);
    src = s; done = d; wr_en = w; wdata = wd; sup = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    src = '0; done = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; done = 1'b0; src = '0; sup = 1'b0; rd_en = 1'b0;
    wr_en = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_chk("R1 reset value", 8'h00);

    // vector table: sources in their own cycle, then strobe, then clear
    for (int i = 0; i < NVEC; i++) begin
      cyc(VECS[i][23:16], 1'b0, 1'b0, 8'h00);
      cyc(8'h00, 1'b1, 1'b0, 8'h00);
      if (VECS[i][15:8] != 8'h00) cyc(8'h00, 1'b0, 1'b1, VECS[i][15:8]);
      read_chk($sformatf("R2/R3/R5/R6 vector %0d", i), VECS[i][7:0]);
    end

    // R7: user mode sees zero and cannot clear
    @(negedge clk); sup = 1'b0; rd_en = 1'b1;
    #1 check("R7 user read", 8'h00);
    rd_en = 1'b0; wr_en = 1'b1; wdata = 8'hFF;
    @(negedge clk); wr_en = 1'b0;
    read_chk("R7 user write ignored", 8'h80);
    @(negedge clk); sup = 1'b1; rd_en = 1'b0;
    #1 check("R7 read enable low", 8'h00);

    // R8: same-cycle strobe (watchdog) and clear of ext+watchdog
    cyc(8'h20, 1'b1, 1'b1, 8'hA0);
    read_chk("R8 completion wins clear", 8'h20);

    // R3: power-up with watchdog discards earlier contents
    cyc(8'h60, 1'b1, 1'b0, 8'h00);
    read_chk("R3 power-up overrides", 8'hC0);

    // R4 and R2 gathering across cycles
    cyc(8'h00, 1'b0, 1'b1, 8'hFF);
    read_chk("R5 clear all", 8'h00);
    cyc(8'h04, 1'b0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    read_chk("R4 hold without completion", 8'h00);
    cyc(8'h00, 1'b1, 1'b0, 8'h00);
    read_chk("R2 gathered loss of clock", 8'h04);
    cyc(8'h00, 1'b1, 1'b0, 8'h00);
    read_chk("R2 gather cleared by completion", 8'h04);
    cyc(8'h08, 1'b0, 1'b1, 8'h08);
    read_chk("R6 reserved write ignored", 8'h04);

    // R1: asynchronous reset mid-run
    @(negedge clk); #2 rst_n = 1'b0; sup = 1'b1; rd_en = 1'b1;
    #1 check("R1 async clear", 8'h00);
    @(negedge clk); rst_n = 1'b1; rd_en = 1'b0;
    read_chk("R1 after release", 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule